// File: doc/BRIEF.md
# Asynchronous Receive Acknowledge Generator

This block picks the 4-bit acknowledge code for every asynchronous request packet taken into one of two receive queues, a bulk queue and a control queue. At packet start the receive path presents the transaction kind, the target queue and the payload length declared in the header (in bytes). Payload quadlets follow, one per `pay_valid` beat. A packet-end strobe carries the CRC result. The block counts the quadlets that actually arrived, checks the count against the declared length rounded up to whole quadlets, and one cycle later presents a valid-qualified acknowledge code.

Each queue has its own pending-enable bit. For good write and lock requests, this bit chooses between the complete and pending answers. A read request that arrives intact is always answered with pending. A CRC failure, or a payload count that differs from the header, turns any answer into a data error. Computing the CRC and sending the acknowledge are handled by neighbouring blocks.

Top module: `async_rx_ack_gen`

## Requirements
- R1: Acknowledge codes are complete = 4'b0001, pending = 4'b0010 and data error = 4'b1101. After reset, `ack_valid` is 0 and `ack_code` is 4'b0000.
- R2: An intact write (`pkt_kind` 2'b01), lock (2'b10) or other (2'b11) request with `pkt_queue` = 0 (bulk) gets pending when `bulk_pend_en` is 1 and complete when it is 0. The enable is sampled in the `pkt_end` cycle.
- R3: An intact write, lock or other request with `pkt_queue` = 1 (control) follows `ctrl_pend_en` in the same way. `bulk_pend_en` has no effect on it.
- R4: An intact read request (`pkt_kind` 2'b00) gets pending in either queue, whatever the values of both enable bits.
- R5: `crc_ok` = 0 in the `pkt_end` cycle gives data error, whatever the kind, queue or enable bits.
- R6: The expected quadlet count is the declared byte length divided by four and rounded up. A length of 0 expects no quadlets. A received count above or below the expected count gives data error.
- R7: `ack_valid` is high for exactly the one cycle after each `pkt_end` cycle and is low at all other times. `ack_code` changes only in the cycle after a `pkt_end` and holds its value until the next one.
- R8: `pkt_start` clears the quadlet count, so quadlets from a packet that was abandoned without `pkt_end` are not counted in the next packet. A beat that arrives in the `pkt_start` cycle counts for the new packet.
- R9: When `pkt_start` and `pkt_end` occur in the same cycle, that cycle's kind, queue, length and beat are used for the decision.
- R10: The quadlet counter saturates and does not wrap. A packet that carries more quadlets than the counter can hold gets data error, even when the wrapped count would equal the expected count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | First cycle of a packet; header fields valid |
| pkt_kind | input | 2 | Transaction kind: 00 read, 01 write, 10 lock, 11 other |
| pkt_queue | input | 1 | Target queue: 0 bulk, 1 control |
| decl_len | input | LEN_W | Declared payload length in bytes |
| pay_valid | input | 1 | One payload quadlet received this cycle |
| pkt_end | input | 1 | Last cycle of a packet |
| crc_ok | input | 1 | Payload CRC good, sampled with pkt_end |
| bulk_pend_en | input | 1 | Bulk queue: pending (1) or complete (0) for good writes and locks |
| ctrl_pend_en | input | 1 | Control queue: pending (1) or complete (0) for good writes and locks |
| ack_valid | output | 1 | One-cycle strobe qualifying ack_code |
| ack_code | output | 4 | Selected acknowledge code |

## Verification
On every cycle the assertions check the following: the strobe is timed from the packet end, the code is held between packets, a CRC failure forces the error code, a read never gets complete, and a queue whose enable is low never gets pending. They also check that an empty single-cycle packet is not treated as a length error and that every strobed code is one of the three legal values. These properties do not know the quadlet count, so only the bench scenarios can show the following: that the exact code is chosen, that the length is rounded up, that too many or too few quadlets are caught, that an abandoned packet leaves no count behind, and that the saturating counter catches a count that would otherwise wrap.

// File: rtl/ack_gen_pkg.sv
package ack_gen_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_LOCK  = 2'b10,
    KIND_OTHER = 2'b11
  } rx_kind_e;

  localparam logic [3:0] ACK_NONE     = 4'b0000;
  localparam logic [3:0] ACK_COMPLETE = 4'b0001;
  localparam logic [3:0] ACK_PENDING  = 4'b0010;
  localparam logic [3:0] ACK_DATA_ERR = 4'b1101;

  typedef struct packed {
    rx_kind_e kind;
    logic     queue;
  } rx_hdr_t;

endpackage

// File: rtl/rx_hdr_latch.sv
module rx_hdr_latch
  import ack_gen_pkg::*;
#(
  parameter int LEN_W = 16,
  localparam int QW   = LEN_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       kind_in,
  input  logic             queue_in,
  input  logic [LEN_W-1:0] len_in,
  output rx_hdr_t          hdr_eff,
  output logic [QW-1:0]    exp_eff
);

  logic [LEN_W:0]  len_rnd;
  logic [QW-1:0]   exp_now;
  rx_hdr_t         hdr_now;
  rx_hdr_t         hdr_q, hdr_d;
  logic [QW-1:0]   exp_q, exp_d;

  // Round the byte length up to whole quadlets.
  always_comb begin
    len_rnd = {1'b0, len_in} + (LEN_W+1)'(3);
    exp_now = len_rnd[LEN_W:2];
    hdr_now.kind  = rx_kind_e'(kind_in);
    hdr_now.queue = queue_in;
  end

  always_comb begin
    hdr_d = hdr_q;
    exp_d = exp_q;
    if (start) begin
      hdr_d = hdr_now;
      exp_d = exp_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '{kind: KIND_READ, queue: 1'b0};
      exp_q <= '0;
    end else if (start) begin
      hdr_q <= hdr_d;
      exp_q <= exp_d;
    end
  end

  // The start cycle takes the header straight from the inputs (single-cycle packets).
  always_comb begin
    hdr_eff = start ? hdr_now : hdr_q;
    exp_eff = start ? exp_now : exp_q;
  end

endmodule

// File: rtl/rx_quad_counter.sv
module rx_quad_counter #(
  parameter int QW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          beat,
  output logic [QW-1:0] total,
  output logic          total_ovf
);

  logic [QW-1:0] cnt_q;
  logic          ovf_q;
  logic [QW-1:0] base;
  logic          base_ovf;
  logic          at_max;
  logic          cnt_en;

  always_comb begin
    base      = start ? '0   : cnt_q;
    base_ovf  = start ? 1'b0 : ovf_q;
    at_max    = &base;
    total     = (at_max || !beat) ? base : base + QW'(1);
    total_ovf = base_ovf | (at_max & beat);
    cnt_en    = start | beat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= total;
      ovf_q <= total_ovf;
    end
  end

endmodule

// File: rtl/ack_code_select.sv
module ack_code_select
  import ack_gen_pkg::*;
(
  input  rx_hdr_t    hdr,
  input  logic       crc_good,
  input  logic       len_bad,
  input  logic       bulk_pend,
  input  logic       ctrl_pend,
  output logic [3:0] code
);

  logic pend_sel;

  always_comb begin
    pend_sel = hdr.queue ? ctrl_pend : bulk_pend;
    if (!crc_good || len_bad)
      code = ACK_DATA_ERR;
    else if (hdr.kind == KIND_READ)
      code = ACK_PENDING;
    else if (pend_sel)
      code = ACK_PENDING;
    else
      code = ACK_COMPLETE;
  end

endmodule

// File: rtl/async_rx_ack_gen.sv
module async_rx_ack_gen
  import ack_gen_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_start,
  input  logic [1:0]       pkt_kind,
  input  logic             pkt_queue,
  input  logic [LEN_W-1:0] decl_len,
  input  logic             pay_valid,
  input  logic             pkt_end,
  input  logic             crc_ok,
  input  logic             bulk_pend_en,
  input  logic             ctrl_pend_en,
  output logic             ack_valid,
  output logic [3:0]       ack_code
);

  localparam int QW = LEN_W - 1;

  rx_hdr_t       hdr_eff;
  logic [QW-1:0] exp_eff;
  logic [QW-1:0] total;
  logic          total_ovf;
  logic          len_bad;
  logic [3:0]    code_sel;
  logic          vld_d;
  logic [3:0]    code_d;

  rx_hdr_latch #(.LEN_W(LEN_W)) u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (pkt_start),
    .kind_in  (pkt_kind),
    .queue_in (pkt_queue),
    .len_in   (decl_len),
    .hdr_eff  (hdr_eff),
    .exp_eff  (exp_eff)
  );

  rx_quad_counter #(.QW(QW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (pkt_start),
    .beat      (pay_valid),
    .total     (total),
    .total_ovf (total_ovf)
  );

  always_comb len_bad = total_ovf | (total != exp_eff);

  ack_code_select u_sel (
    .hdr       (hdr_eff),
    .crc_good  (crc_ok),
    .len_bad   (len_bad),
    .bulk_pend (bulk_pend_en),
    .ctrl_pend (ctrl_pend_en),
    .code      (code_sel)
  );

  always_comb begin
    vld_d  = pkt_end;
    code_d = pkt_end ? code_sel : ack_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack_code  <= ACK_NONE;
    end else begin
      ack_valid <= vld_d;
      if (pkt_end) ack_code <= code_d;
    end
  end

endmodule

// File: rtl/ack_gen_chk.sv
module ack_gen_chk
  import ack_gen_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_start,
  input logic [1:0]       pkt_kind,
  input logic             pkt_queue,
  input logic [LEN_W-1:0] decl_len,
  input logic             pay_valid,
  input logic             pkt_end,
  input logic             crc_ok,
  input logic             bulk_pend_en,
  input logic             ctrl_pend_en,
  input logic             ack_valid,
  input logic [3:0]       ack_code
);

  // Separate copy of the header kind and queue, kept by the checker itself.
  logic       sh_read;
  logic       sh_queue;
  logic       rd_now;
  logic       q_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_read  <= 1'b0;
      sh_queue <= 1'b0;
    end else if (pkt_start) begin
      sh_read  <= (pkt_kind == 2'b00);
      sh_queue <= pkt_queue;
    end
  end

  always_comb begin
    rd_now = pkt_start ? (pkt_kind == 2'b00) : sh_read;
    q_now  = pkt_start ? pkt_queue : sh_queue;
  end

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (ack_code == 4'b0001 || ack_code == 4'b0010 || ack_code == 4'b1101)); // R1

  AST_BULK_OFF_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && !rd_now && !q_now && !bulk_pend_en) |=> (ack_code != 4'b0010)); // R2

  AST_CTRL_OFF_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && !rd_now && q_now && !ctrl_pend_en) |=> (ack_code != 4'b0010)); // R3

  AST_READ_NOT_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && rd_now) |=> (ack_code != 4'b0001)); // R4

  AST_CRC_FORCES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && !crc_ok) |=> (ack_code == 4'b1101)); // R5

  AST_VALID_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> ack_valid); // R7

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_end |=> !ack_valid); // R7

  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_end |=> $stable(ack_code)); // R7

  AST_EMPTY_SINGLE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && pkt_end && !pay_valid && decl_len == '0 && crc_ok)
      |=> (ack_code != 4'b1101)); // R9

endmodule

bind async_rx_ack_gen ack_gen_chk #(.LEN_W(LEN_W)) i_chk (.*);

// File: tb/test_async_rx_ack_gen.sv
module test_async_rx_ack_gen;

  logic        clk;
  logic        rst_n;
  logic        pkt_start;
  logic [1:0]  pkt_kind;
  logic        pkt_queue;
  logic [15:0] decl_len;
  logic        pay_valid;
  logic        pkt_end;
  logic        crc_ok;
  logic        bulk_pend_en;
  logic        ctrl_pend_en;
  logic        ack_valid;
  logic [3:0]  ack_code;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  async_rx_ack_gen #(.LEN_W(16)) i_async_rx_ack_gen (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  kind;
    logic        q;
    logic [15:0] len;
    logic [7:0]  nq;
    logic        crc;
    logic        bpe;
    logic        cpe;
    logic [3:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 1'b0, 16'd8,  8'd2, 1'b1, 1'b1, 1'b0, 4'h2, 4'd2},  // R2 bulk write, pending
    '{2'b01, 1'b0, 16'd8,  8'd2, 1'b1, 1'b0, 1'b1, 4'h1, 4'd2},  // R2 bulk write, complete
    '{2'b10, 1'b1, 16'd4,  8'd1, 1'b1, 1'b0, 1'b1, 4'h2, 4'd3},  // R3 ctrl lock, pending
    '{2'b10, 1'b1, 16'd4,  8'd1, 1'b1, 1'b1, 1'b0, 4'h1, 4'd3},  // R3 ctrl lock, complete
    '{2'b00, 1'b0, 16'd0,  8'd0, 1'b1, 1'b0, 1'b0, 4'h2, 4'd4},  // R4 bulk read
    '{2'b00, 1'b1, 16'd0,  8'd0, 1'b1, 1'b1, 1'b1, 4'h2, 4'd4},  // R4 ctrl read
    '{2'b01, 1'b0, 16'd8,  8'd2, 1'b0, 1'b1, 1'b1, 4'hD, 4'd5},  // R5 bad CRC on write
    '{2'b00, 1'b1, 16'd0,  8'd0, 1'b0, 1'b0, 1'b0, 4'hD, 4'd5},  // R5 bad CRC on read
    '{2'b01, 1'b1, 16'd5,  8'd2, 1'b1, 1'b1, 1'b1, 4'h2, 4'd6},  // R6 5 bytes -> 2 quadlets
    '{2'b01, 1'b1, 16'd5,  8'd1, 1'b1, 1'b0, 1'b0, 4'hD, 4'd6},  // R6 too few
    '{2'b01, 1'b0, 16'd0,  8'd0, 1'b1, 1'b0, 1'b0, 4'h1, 4'd6},  // R6 zero length
    '{2'b01, 1'b0, 16'd0,  8'd1, 1'b1, 1'b1, 1'b1, 4'hD, 4'd6},  // R6 payload on zero length
    '{2'b10, 1'b0, 16'd12, 8'd4, 1'b1, 1'b1, 1'b0, 4'hD, 4'd6},  // R6 too many
    '{2'b11, 1'b1, 16'd16, 8'd4, 1'b1, 1'b0, 1'b1, 4'h2, 4'd3}   // R3 other kind follows enable
  };

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    pkt_start = 1'b0; pkt_end = 1'b0; pay_valid = 1'b0;
  endtask

  // Sends one packet; enables and CRC are given wrong values until the end cycle.
  task automatic send(input logic [1:0] k, input logic q, input logic [15:0] len,
                      input int nq, input logic crc, input logic bpe, input logic cpe,
                      input logic [3:0] exp, input string tag);
    @(negedge clk);
    pkt_start = 1'b1; pkt_kind = k; pkt_queue = q; decl_len = len;
    pay_valid = 1'b0; pkt_end = 1'b0;
    crc_ok = ~crc; bulk_pend_en = ~bpe; ctrl_pend_en = ~cpe;
    @(negedge clk);
    pkt_start = 1'b0; pkt_kind = ~k; pkt_queue = ~q; decl_len = ~len;
    for (int i = 0; i < nq; i++) begin
      pay_valid = 1'b1;
      if (i == nq - 1) begin
        pkt_end = 1'b1; crc_ok = crc; bulk_pend_en = bpe; ctrl_pend_en = cpe;
      end
      @(negedge clk);
    end
    if (nq == 0) begin
      pay_valid = 1'b0;
      pkt_end = 1'b1; crc_ok = crc; bulk_pend_en = bpe; ctrl_pend_en = cpe;
      @(negedge clk);
    end
    idle_inputs();
    check({3'b0, ack_valid}, 4'h1, {tag, " ack_valid after end (R7)"});
    check(ack_code, exp, {tag, " ack_code"});
    @(negedge clk);
    check({3'b0, ack_valid}, 4'h0, {tag, " ack_valid drops (R7)"});
    check(ack_code, exp, {tag, " ack_code held (R7)"});
  endtask

  initial begin : watchdog
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    pkt_kind = 2'b00; pkt_queue = 1'b0; decl_len = '0;
    crc_ok = 1'b1; bulk_pend_en = 1'b0; ctrl_pend_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({3'b0, ack_valid}, 4'h0, "R1 reset ack_valid");
    check(ack_code, 4'h0, "R1 reset ack_code");
    rst_n = 1'b1;
    @(negedge clk);
    check({3'b0, ack_valid}, 4'h0, "R1 idle after reset");

    for (int v = 0; v < NV; v++) begin
      send(VEC[v].kind, VEC[v].q, VEC[v].len, int'(VEC[v].nq), VEC[v].crc,
           VEC[v].bpe, VEC[v].cpe, VEC[v].exp, $sformatf("R%0d vec%0d", VEC[v].req, v));
    end

    // R7: the code holds over idle cycles
    repeat (5) @(negedge clk);
    check(ack_code, VEC[NV-1].exp, "R7 code held while idle");
    check({3'b0, ack_valid}, 4'h0, "R7 no strobe while idle");

    // R8: abandoned packet, then a new packet with a beat in its start cycle
    @(negedge clk);
    pkt_start = 1'b1; pkt_kind = 2'b01; pkt_queue = 1'b0; decl_len = 16'd16;
    @(negedge clk);
    pkt_start = 1'b0; pay_valid = 1'b1;
    repeat (3) @(negedge clk);
    pay_valid = 1'b1; pkt_start = 1'b1; pkt_kind = 2'b01; pkt_queue = 1'b0; decl_len = 16'd4;
    @(negedge clk);
    pkt_start = 1'b0; pay_valid = 1'b0;
    pkt_end = 1'b1; crc_ok = 1'b1; bulk_pend_en = 1'b0; ctrl_pend_en = 1'b1;
    @(negedge clk);
    idle_inputs();
    check({3'b0, ack_valid}, 4'h1, "R8 strobe after restart");
    check(ack_code, 4'h1, "R8 count cleared by start");

    // R9: single-cycle packet with one beat
    @(negedge clk);
    pkt_start = 1'b1; pkt_end = 1'b1; pay_valid = 1'b1;
    pkt_kind = 2'b01; pkt_queue = 1'b1; decl_len = 16'd3;
    crc_ok = 1'b1; bulk_pend_en = 1'b0; ctrl_pend_en = 1'b1;
    @(negedge clk);
    idle_inputs();
    check({3'b0, ack_valid}, 4'h1, "R9 strobe single-cycle");
    check(ack_code, 4'h2, "R9 single-cycle write");

    // R9: single-cycle empty read, after an error code to make the change visible
    send(2'b01, 1'b0, 16'd4, 0, 1'b1, 1'b0, 1'b0, 4'hD, "R6 missing payload");
    @(negedge clk);
    pkt_start = 1'b1; pkt_end = 1'b1; pay_valid = 1'b0;
    pkt_kind = 2'b00; pkt_queue = 1'b0; decl_len = 16'd0;
    crc_ok = 1'b1; bulk_pend_en = 1'b0; ctrl_pend_en = 1'b0;
    @(negedge clk);
    idle_inputs();
    check(ack_code, 4'h2, "R9 single-cycle empty read");

    // R10: 32769 quadlets against one expected; a 15-bit wrap would match
    @(negedge clk);
    pkt_start = 1'b1; pkt_kind = 2'b01; pkt_queue = 1'b0; decl_len = 16'd4;
    crc_ok = 1'b1; bulk_pend_en = 1'b0; ctrl_pend_en = 1'b0;
    @(negedge clk);
    pkt_start = 1'b0;
    for (int i = 0; i < 32769; i++) begin
      pay_valid = 1'b1;
      pkt_end = (i == 32768);
      @(negedge clk);
    end
    idle_inputs();
    check({3'b0, ack_valid}, 4'h1, "R10 strobe after long packet");
    check(ack_code, 4'hD, "R10 saturated count is an error");

    // R2: a normal bulk write after saturation is unaffected
    send(2'b01, 1'b0, 16'd4, 1, 1'b1, 1'b0, 1'b1, 4'h1, "R2 after saturation");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule